// File: doc/BRIEF.md
# Two-Rail Serial Word Transmitter

This block takes one data word from a 16-bit parallel bus, delivered as two halves under separate write strobes, and sends it as a return-to-zero serial word on a pair of rails. One rail is high for a one bit and the other is high for a zero bit. The bus halves use a shuffled layout, so the block first rebuilds the serial word. It then appends a generated parity bit and shifts the word out with the first serial bit first.

The bit cell is 10 or 80 input clocks long, chosen by a rate input. Each cell is driven for its first half and held null for its second half. A word is 32 bits, or 25 bits when the short-word input is set. After the last bit comes a null gap of four bit times. Only then does the ready flag rise again.

The block holds one word in its holding halves. A start request while ready launches that word. The rate, parity and length inputs are captured at the start. Loads and start requests made while busy have no effect.

Top module: `arincTx`

## Requirements
- R1: After reset, txReady is 1 and both lineHi and lineLo are 0.
- R2: The bit cell lasts 10 clock cycles when rateSlow is 0 at the start request, and 80 cycles when it is 1. The first bit cell begins in the cycle after the start is accepted.
- R3: In each bit cell, exactly one rail is high during the first half (cell/2 cycles): lineHi for a 1 and lineLo for a 0. Both rails are 0 during the second half and whenever no bit is being sent.
- R4: Serial bit 1 is sent first. The first bus half (loadLow) maps as follows: bus bit 7 down to bus bit 0 give serial bits 1 to 8; bus bit 11 gives bit 9; bus bit 12 gives bit 10; bus bit 13 gives bit 11; bus bit 14 gives bit 12; bus bit 15 gives bit 13; bus bit 9 gives bit 30; bus bit 10 gives bit 31. Bus bit 8 is ignored.
- R5: The second bus half (loadHigh) carries serial bits 14 to 29, with bus bit 0 as bit 14.
- R6: In 32-bit mode (shortWord = 0), bit 32 is the parity over bits 1 to 31. With parityEven = 0, the 32 bits hold an odd number of ones. With parityEven = 1, they hold an even number.
- R7: In 25-bit mode (shortWord = 1), bits 1 to 24 are sent followed by a parity bit as bit 25. The parity follows the same odd/even rule over those 25 bits.
- R8: txReady drops in the cycle after an accepted start. It stays 0 for the word plus four null bit times, i.e. (N+4) cells, and then returns to 1.
- R9: loadLow, loadHigh and startTx asserted while txReady is 0 are ignored. The next start resends the word previously held.
- R10: rateSlow, parityEven and shortWord are sampled at the accepted start. Changing them during a word does not change that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, ten times the fast bit rate |
| rst_n | input | 1 | Active-low reset |
| busData | input | 16 | Parallel data for the holding halves |
| loadLow | input | 1 | Write strobe for the first (shuffled) bus half |
| loadHigh | input | 1 | Write strobe for the second bus half |
| startTx | input | 1 | Request to send the held word |
| rateSlow | input | 1 | 0: cell of 10 clocks, 1: cell of 80 clocks |
| parityEven | input | 1 | 0: odd parity, 1: even parity |
| shortWord | input | 1 | 0: 32-bit word, 1: 25-bit word |
| txReady | output | 1 | High when idle and able to accept loads and a start |
| lineHi | output | 1 | Data-true rail, return-to-zero |
| lineLo | output | 1 | Data-not rail, return-to-zero |

## Verification
The hardest case to reach is a word whose configuration and holding data are disturbed while it is in flight. It must still come out exactly as captured, and the word after it must reuse the old holding contents. The stimulus reaches this by asserting loads with a different pattern, a start request, and inverted configuration inputs fifty cycles into a word. It then starts a second word with no reload and compares both words cell by cell against an independently rebuilt bit vector. The comparison covers every combination of rate, parity sense and length.

// File: rtl/arincTxPkg.sv
package arincTxPkg;
  typedef struct packed {
    logic wrLow;
    logic wrHigh;
    logic capture;
    logic shift;
  } txStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_GAP  = 2'd2
  } txState_t;
endpackage

// File: rtl/arincTxDatapath.sv
module arincTxDatapath
  import arincTxPkg::*;
#(
  parameter int HALF_W = 16,
  parameter int WORD_W = 32,
  parameter int SHORT_W = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HALF_W-1:0] busData,
  input  txStrobes_t        strb,
  input  logic              parityEven,
  input  logic              shortWord,
  output logic              curBit
);
  localparam int LABEL_W = 8;
  localparam int MID_LO  = 13;

  logic [HALF_W-1:0] lowHalf, highHalf;
  logic [WORD_W-1:0] rebuilt, loadVal, shiftReg;
  logic longPar, shortPar;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lowHalf  <= '0;
      highHalf <= '0;
    end else begin
      if (strb.wrLow)  lowHalf  <= busData;
      if (strb.wrHigh) highHalf <= busData;
    end
  end

  // label bits are reversed on the bus
  for (genvar i = 0; i < LABEL_W; i++) begin : g_label
    assign rebuilt[i] = lowHalf[LABEL_W-1-i];
  end

  assign rebuilt[8]  = lowHalf[11];
  assign rebuilt[9]  = lowHalf[12];
  assign rebuilt[10] = lowHalf[13];
  assign rebuilt[11] = lowHalf[14];
  assign rebuilt[12] = lowHalf[15];
  assign rebuilt[MID_LO+HALF_W-1:MID_LO] = highHalf;
  assign rebuilt[29] = lowHalf[9];
  assign rebuilt[30] = lowHalf[10];
  assign rebuilt[31] = 1'b0;

  always_comb begin
    longPar  = ~(^rebuilt[WORD_W-2:0]) ^ parityEven;
    shortPar = ~(^rebuilt[SHORT_W-2:0]) ^ parityEven;
    if (shortWord)
      loadVal = {{(WORD_W-SHORT_W){1'b0}}, shortPar, rebuilt[SHORT_W-2:0]};
    else
      loadVal = {longPar, rebuilt[WORD_W-2:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      shiftReg <= '0;
    else if (strb.capture)
      shiftReg <= loadVal;
    else if (strb.shift)
      shiftReg <= {1'b0, shiftReg[WORD_W-1:1]};
  end

  assign curBit = shiftReg[0];
endmodule

// File: rtl/arincTxControl.sv
module arincTxControl
  import arincTxPkg::*;
#(
  parameter int FAST_DIV = 10,
  parameter int SLOW_DIV = 80,
  parameter int GAP_BITS = 4,
  parameter int WORD_W = 32,
  parameter int SHORT_W = 25
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       loadLow,
  input  logic       loadHigh,
  input  logic       startTx,
  input  logic       rateSlow,
  input  logic       shortWord,
  output txStrobes_t strb,
  output logic       sending,
  output logic       firstHalf,
  output logic       txReady
);
  localparam int CNT_W = $clog2(SLOW_DIV + 1);
  localparam int BIT_W = $clog2(WORD_W + GAP_BITS + 1);

  txState_t state;
  logic [CNT_W-1:0] cellCnt, cellLen;
  logic [BIT_W-1:0] bitCnt, lastIdx;
  logic slowLat, shortLat, idle, cellEnd, lastCell;

  assign idle    = (state == ST_IDLE);
  assign cellLen = slowLat ? CNT_W'(SLOW_DIV) : CNT_W'(FAST_DIV);
  assign cellEnd = (cellCnt == cellLen - 1'b1);
  always_comb begin
    if (state == ST_SEND)
      lastIdx = shortLat ? BIT_W'(SHORT_W - 1) : BIT_W'(WORD_W - 1);
    else
      lastIdx = BIT_W'(GAP_BITS - 1);
  end
  assign lastCell = (bitCnt == lastIdx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cellCnt  <= '0;
      bitCnt   <= '0;
      slowLat  <= 1'b0;
      shortLat <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (startTx) begin
            state    <= ST_SEND;
            cellCnt  <= '0;
            bitCnt   <= '0;
            slowLat  <= rateSlow;
            shortLat <= shortWord;
          end
        end
        default: begin
          if (cellEnd) begin
            cellCnt <= '0;
            if (lastCell) begin
              bitCnt <= '0;
              state  <= (state == ST_SEND) ? ST_GAP : ST_IDLE;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end else begin
            cellCnt <= cellCnt + 1'b1;
          end
        end
      endcase
    end
  end

  always_comb begin
    strb.wrLow   = idle && loadLow;
    strb.wrHigh  = idle && loadHigh;
    strb.capture = idle && startTx;
    strb.shift   = (state == ST_SEND) && cellEnd;
  end

  assign sending   = (state == ST_SEND);
  assign firstHalf = (cellCnt < (cellLen >> 1));
  assign txReady   = idle;
endmodule

// File: rtl/arincTx.sv
module arincTx
  import arincTxPkg::*;
#(
  parameter int FAST_DIV = 10,
  parameter int SLOW_DIV = 80,
  parameter int GAP_BITS = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] busData,
  input  logic        loadLow,
  input  logic        loadHigh,
  input  logic        startTx,
  input  logic        rateSlow,
  input  logic        parityEven,
  input  logic        shortWord,
  output logic        txReady,
  output logic        lineHi,
  output logic        lineLo
);
  txStrobes_t strb;
  logic curBit, sending, firstHalf, drive;

  arincTxControl #(
    .FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV), .GAP_BITS(GAP_BITS),
    .WORD_W(32), .SHORT_W(25)
  ) u_ctl (
    .clk(clk), .rst_n(rst_n), .loadLow(loadLow), .loadHigh(loadHigh),
    .startTx(startTx), .rateSlow(rateSlow), .shortWord(shortWord),
    .strb(strb), .sending(sending), .firstHalf(firstHalf), .txReady(txReady)
  );

  arincTxDatapath #(.HALF_W(16), .WORD_W(32), .SHORT_W(25)) u_dp (
    .clk(clk), .rst_n(rst_n), .busData(busData), .strb(strb),
    .parityEven(parityEven), .shortWord(shortWord), .curBit(curBit)
  );

  assign drive  = sending && firstHalf;
  assign lineHi = drive && curBit;
  assign lineLo = drive && !curBit;
endmodule

// File: rtl/arincTxChecker.sv
module arincTxChecker (
  input logic clk,
  input logic rst_n,
  input logic startTx,
  input logic txReady,
  input logic lineHi,
  input logic lineLo
);
  // R3
  never_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(lineHi && lineLo));

  // R3
  idle_null_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txReady |-> (!lineHi && !lineLo));

  // R8
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txReady && startTx) |=> !txReady);

  // R8
  gap_before_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(txReady) |-> ($past(!lineHi) && $past(!lineLo)));

  // R2
  hi_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lineHi) |=> lineHi);

  // R2
  lo_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lineLo) |=> lineLo);
endmodule

bind arincTx arincTxChecker u_chk (
  .clk(clk), .rst_n(rst_n), .startTx(startTx), .txReady(txReady),
  .lineHi(lineHi), .lineLo(lineLo)
);

// File: tb/arincTx_test.sv
module arincTx_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] busData = '0;
  logic loadLow = 0, loadHigh = 0, startTx = 0;
  logic rateSlow = 0, parityEven = 0, shortWord = 0;
  logic txReady, lineHi, lineLo;
  int testsRun = 0, testsFailed = 0;
  bit done = 0;

  arincTx uut (
    .clk(clk), .rst_n(rst_n), .busData(busData), .loadLow(loadLow),
    .loadHigh(loadHigh), .startTx(startTx), .rateSlow(rateSlow),
    .parityEven(parityEven), .shortWord(shortWord), .txReady(txReady),
    .lineHi(lineHi), .lineLo(lineLo)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // expected serial bit n (1-based), built from the requirement mapping
  function automatic logic [31:0] expWord(input logic [15:0] w1, input logic [15:0] w2,
                                           input bit even, input bit shrt);
    logic [32:1] a;
    int ones, n;
    a = '0;
    for (int i = 1; i <= 8; i++) a[i] = w1[8-i];        // R4
    a[9] = w1[11]; a[10] = w1[12]; a[11] = w1[13];
    a[12] = w1[14]; a[13] = w1[15];
    a[30] = w1[9]; a[31] = w1[10];
    for (int i = 0; i < 16; i++) a[14+i] = w2[i];       // R5
    n = shrt ? 25 : 32;
    ones = 0;
    for (int i = 1; i < n; i++) ones += a[i];
    a[n] = even ? (ones % 2) : ((ones % 2) == 0);        // R6 R7
    if (shrt) for (int i = 26; i <= 32; i++) a[i] = 1'b0;
    return a;
  endfunction

  task automatic sendWord(input logic [15:0] w1, input logic [15:0] w2, input bit doLoad,
                          input bit slow, input bit even, input bit shrt, input bit disturb);
    logic [32:1] e;
    int p, n, total, b, pos;
    bit eh, el;
    e = expWord(w1, w2, even, shrt);
    p = slow ? 80 : 10;
    n = shrt ? 25 : 32;
    total = (n + 4) * p;
    if (doLoad) begin
      busData = w1; loadLow = 1;
      @(negedge clk); loadLow = 0; busData = w2; loadHigh = 1;
      @(negedge clk); loadHigh = 0;
    end
    rateSlow = slow; parityEven = even; shortWord = shrt;
    check(txReady === 1'b1, "R8 ready before start", txReady, 1);
    startTx = 1;
    @(negedge clk); startTx = 0;
    for (int j = 0; j < total; j++) begin
      b = j / p; pos = j % p;
      eh = (b < n) && (pos < p/2) && e[b+1];
      el = (b < n) && (pos < p/2) && !e[b+1];
      check(lineHi === eh, $sformatf("R4 R5 R6 R7 lineHi bit %0d pos %0d", b+1, pos), lineHi, eh);
      check(lineLo === el, $sformatf("R2 R3 lineLo bit %0d pos %0d", b+1, pos), lineLo, el);
      check(txReady === 1'b0, "R8 busy", txReady, 0);
      if (disturb && j == 50) begin
        busData = ~w1 ^ 16'h1234; loadLow = 1; loadHigh = 1; startTx = 1;  // R9
        rateSlow = !slow; parityEven = !even; shortWord = !shrt;            // R10
      end
      if (disturb && j == 51) begin
        loadLow = 0; loadHigh = 0; startTx = 0;
      end
      @(negedge clk);
    end
    check(txReady === 1'b1, "R8 ready after gap", txReady, 1);
    check(!lineHi && !lineLo, "R3 null when idle", {lineHi, lineLo}, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 300000);
    if (!done) begin
      testsFailed++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    logic [15:0] pats [3][2];
    pats[0][0] = 16'h0000; pats[0][1] = 16'h0000;
    pats[1][0] = 16'hFFFF; pats[1][1] = 16'hFFFF;
    pats[2][0] = 16'hA5C3; pats[2][1] = 16'h3C5A;
    repeat (3) @(negedge clk);
    // R1
    check(txReady === 1'b1, "R1 ready in reset", txReady, 1);
    check(!lineHi && !lineLo, "R1 lines in reset", {lineHi, lineLo}, 0);
    rst_n = 1;
    @(negedge clk);
    check(txReady === 1'b1 && !lineHi && !lineLo, "R1 after reset",
          {txReady, lineHi, lineLo}, 3'b100);
    for (int cfg = 0; cfg < 8; cfg++)
      for (int k = 0; k < 3; k++)
        sendWord(pats[k][0], pats[k][1], 1, cfg[0], cfg[1], cfg[2], 0);
    // R9 R10: disturb mid-word, then resend without reload
    sendWord(16'h5AF0, 16'h0F69, 1, 0, 0, 0, 1);
    sendWord(16'h5AF0, 16'h0F69, 0, 0, 0, 0, 0);
    sendWord(16'h8137, 16'hC0DE, 1, 1, 1, 1, 1);
    sendWord(16'h8137, 16'hC0DE, 0, 0, 1, 1, 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule